// File: doc/BRIEF.md
# Fetch-to-Execute Pipeline Register with Taken-Jump Squash

This block is the only register between the instruction fetch stage and a single combined stage that decodes, executes, accesses memory and writes back. On every rising clock edge it captures the fetched instruction word and the program counter it came from. It then holds both on its outputs for the execute stage for the next cycle.

The block handles control hazards by squashing. It looks at the opcode field of the instruction it is currently presenting. If that instruction is a jump and the execute stage reports that the jump's condition passed, the jump is taken. The word being fetched in that same cycle belongs to the wrong path, so the register latches an all-zero bubble in its place. A jump whose condition fails squashes nothing.

Fetch addressing, next-PC selection and condition evaluation are outside this block; the condition result arrives on an input. The block has no handshake. It advances on every edge, and the fetch side must present a word each cycle.

Top module: `pipebar_top`

## Requirements
- R1: While `rst` is sampled high at a rising edge, the outputs become `exec_insn` = 0x00000000 and `exec_pc` = 0. After reset, execute therefore sees one startup bubble. The first word fetched after reset is never squashed.
- R2: When no squash applies, `exec_insn` and `exec_pc` on the cycle after an edge equal the `fetch_insn` and `fetch_pc` sampled at that edge.
- R3: With the default parameters, `exec_insn` is a jump when `exec_insn[31:24] & 8'hF0` equals `8'h40`. When `exec_insn` is a jump and `cond_pass` is 1 at an edge, `exec_insn` becomes exactly 0x00000000 after that edge.
- R4: When `exec_insn` is a jump and `cond_pass` is 0, the fetched word passes through unchanged.
- R5: When `exec_insn` is not a jump, `cond_pass` has no effect and the fetched word passes through.
- R6: For back-to-back jumps, a fetched jump that is squashed by a taken jump never reaches `exec_insn`. The bubble that replaces it squashes nothing, so the following fetched word reaches execute whatever `cond_pass` is.
- R7: `exec_pc` follows `fetch_pc` from the previous edge even when the instruction is squashed. Its value is meaningless whenever `exec_insn` is the bubble.
- R8: Opcode bits that the jump mask clears are ignored. With the defaults, every value 0x40 to 0x4F in `exec_insn[31:24]` is a jump, and every other value is not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fetch_insn | input | 32 | Instruction word from fetch |
| fetch_pc | input | 24 | Program counter of `fetch_insn` |
| cond_pass | input | 1 | Condition result for the instruction now on `exec_insn` |
| exec_insn | output | 32 | Instruction presented to the execute stage |
| exec_pc | output | 24 | Program counter of `exec_insn` |

## Verification
Every result appears exactly one edge after its stimulus. A word and its PC driven before edge N are on the outputs after edge N. A squash decision made on the word present before edge N produces the bubble after edge N. The bench changes inputs only at falling edges and compares outputs at the next falling edge, so each check falls in the cycle the register has just loaded. A sweep visits all 256 opcode values with both condition settings, using a reference model one register deep.

// File: rtl/pipebar_pkg.sv
package pipebar_pkg;
  localparam int INSN_W_DEF = 32;
  localparam int PC_W_DEF   = 24;
  localparam int OPC_W_DEF  = 8;
  localparam int OPC_LSB_DEF = 24;
endpackage

// File: rtl/pb_jump_detect.sv
module pb_jump_detect #(
  parameter int INSN_W  = 32,
  parameter int OPC_LSB = 24,
  parameter int OPC_W   = 8,
  parameter logic [OPC_W-1:0] JUMP_OPC  = 8'h40,
  parameter logic [OPC_W-1:0] JUMP_MASK = 8'hF0
) (
  input  logic [INSN_W-1:0] insn,
  input  logic              cond_pass,
  output logic              is_jump,
  output logic              squash
);
  logic [OPC_W-1:0] opc;
  assign opc     = insn[OPC_LSB +: OPC_W];
  assign is_jump = ((opc & JUMP_MASK) == (JUMP_OPC & JUMP_MASK));
  assign squash  = is_jump && cond_pass;
endmodule

// File: rtl/pb_squash_mux.sv
module pb_squash_mux #(
  parameter int INSN_W = 32
) (
  input  logic [INSN_W-1:0] fetch_insn,
  input  logic              squash,
  output logic [INSN_W-1:0] next_insn
);
  always_comb begin
    if (squash) next_insn = '0;
    else        next_insn = fetch_insn;
  end
endmodule

// File: rtl/pb_stage_reg.sv
module pb_stage_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/pipebar_top.sv
module pipebar_top
  import pipebar_pkg::*;
#(
  parameter int INSN_W  = INSN_W_DEF,
  parameter int PC_W    = PC_W_DEF,
  parameter int OPC_LSB = OPC_LSB_DEF,
  parameter int OPC_W   = OPC_W_DEF,
  parameter logic [OPC_W-1:0] JUMP_OPC  = 8'h40,
  parameter logic [OPC_W-1:0] JUMP_MASK = 8'hF0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [INSN_W-1:0] fetch_insn,
  input  logic [PC_W-1:0]   fetch_pc,
  input  logic              cond_pass,
  output logic [INSN_W-1:0] exec_insn,
  output logic [PC_W-1:0]   exec_pc
);
  localparam int STATE_W = INSN_W + PC_W;

  logic              out_is_jump;
  logic              squash;
  logic [INSN_W-1:0] next_insn;
  logic [STATE_W-1:0] state_d, state_q;

  // Decide on the word currently held, which is the one in execute
  pb_jump_detect #(
    .INSN_W(INSN_W), .OPC_LSB(OPC_LSB), .OPC_W(OPC_W),
    .JUMP_OPC(JUMP_OPC), .JUMP_MASK(JUMP_MASK)
  ) u_detect (
    .insn(exec_insn), .cond_pass(cond_pass),
    .is_jump(out_is_jump), .squash(squash)
  );

  pb_squash_mux #(.INSN_W(INSN_W)) u_mux (
    .fetch_insn(fetch_insn), .squash(squash), .next_insn(next_insn)
  );

  // PC is always captured; it is meaningless alongside a bubble
  assign state_d = {next_insn, fetch_pc};

  pb_stage_reg #(.W(STATE_W)) u_reg (
    .clk(clk), .rst(rst), .d(state_d), .q(state_q)
  );

  assign exec_insn = state_q[STATE_W-1 -: INSN_W];
  assign exec_pc   = state_q[PC_W-1:0];
endmodule

// File: rtl/pipebar_chk.sv
module pipebar_chk #(
  parameter int INSN_W  = 32,
  parameter int PC_W    = 24,
  parameter int OPC_LSB = 24,
  parameter int OPC_W   = 8,
  parameter logic [OPC_W-1:0] JUMP_OPC  = 8'h40,
  parameter logic [OPC_W-1:0] JUMP_MASK = 8'hF0
) (
  input logic              clk,
  input logic              rst,
  input logic [INSN_W-1:0] fetch_insn,
  input logic [PC_W-1:0]   fetch_pc,
  input logic              cond_pass,
  input logic [INSN_W-1:0] exec_insn,
  input logic [PC_W-1:0]   exec_pc
);
  logic jmp;
  assign jmp = ((exec_insn[OPC_LSB +: OPC_W] & JUMP_MASK) == (JUMP_OPC & JUMP_MASK));

  AST_RESET_BUBBLE: assert property (@(posedge clk)
    rst |=> (exec_insn == '0 && exec_pc == '0)); // R1
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
    !(jmp && cond_pass) |=> exec_insn == $past(fetch_insn)); // R2
  AST_TAKEN_SQUASH: assert property (@(posedge clk) disable iff (rst)
    (jmp && cond_pass) |=> exec_insn == '0); // R3
  AST_NOT_TAKEN_KEEP: assert property (@(posedge clk) disable iff (rst)
    (jmp && !cond_pass) |=> exec_insn == $past(fetch_insn)); // R4
  AST_AFTER_BUBBLE: assert property (@(posedge clk) disable iff (rst)
    (jmp && cond_pass) |=> ##1 exec_insn == $past(fetch_insn)); // R6
  AST_PC_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> exec_pc == $past(fetch_pc)); // R7
endmodule

bind pipebar_top pipebar_chk #(
  .INSN_W(INSN_W), .PC_W(PC_W), .OPC_LSB(OPC_LSB), .OPC_W(OPC_W),
  .JUMP_OPC(JUMP_OPC), .JUMP_MASK(JUMP_MASK)
) u_chk (
  .clk(clk), .rst(rst), .fetch_insn(fetch_insn), .fetch_pc(fetch_pc),
  .cond_pass(cond_pass), .exec_insn(exec_insn), .exec_pc(exec_pc)
);

// File: tb/pipebar_top_test.sv
module pipebar_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] fetch_insn = '0;
  logic [23:0] fetch_pc = '0;
  logic        cond_pass = 1'b0;
  logic [31:0] exec_insn;
  logic [23:0] exec_pc;

  int total = 0;
  int bad = 0;
  logic [31:0] m_insn;
  logic [23:0] m_pc;

  always #4 clk = ~clk;

  pipebar_top uut (
    .clk(clk), .rst(rst), .fetch_insn(fetch_insn), .fetch_pc(fetch_pc),
    .cond_pass(cond_pass), .exec_insn(exec_insn), .exec_pc(exec_pc)
  );

  function automatic bit is_jmp(input logic [31:0] w);
    return (w[31:24] & 8'hF0) == 8'h40;
  endfunction

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge; applies inputs, checks after the next rising edge
  task automatic step(input logic [31:0] w, input logic [23:0] pc, input logic cp, input string req);
    logic [31:0] exp_i;
    fetch_insn = w; fetch_pc = pc; cond_pass = cp;
    exp_i = (is_jmp(m_insn) && cp) ? 32'h0 : w;
    @(posedge clk); @(negedge clk);
    check32(req, exec_insn, exp_i);
    check32("R7", {8'h0, exec_pc}, {8'h0, pc});
    m_insn = exp_i; m_pc = pc;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    fetch_insn = 32'h4123_4567; fetch_pc = 24'hABCDEF; cond_pass = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check32("R1", exec_insn, 32'h0);                 // R1 reset bubble
    check32("R1", {8'h0, exec_pc}, 32'h0);
    rst = 1'b0;
    m_insn = '0; m_pc = '0;
    // R1 startup: first fetch not squashed even with cond_pass high
    step(32'h4000_0010, 24'h000001, 1'b1, "R1");
    // R3 taken jump in execute squashes next fetch
    step(32'h1111_1111, 24'h000002, 1'b1, "R3");
    // R6 bubble squashes nothing
    step(32'h2222_2222, 24'h000003, 1'b1, "R6");
    // R4 not-taken jump
    step(32'h4F00_0001, 24'h000004, 1'b0, "R5");
    step(32'h3333_3333, 24'h000005, 1'b0, "R4");
    // R6 back-to-back jumps: taken jump squashes a fetched jump
    step(32'h4500_0000, 24'h000006, 1'b1, "R5");
    step(32'h4600_0000, 24'h000007, 1'b1, "R6");
    step(32'h4700_0000, 24'h000008, 1'b1, "R6");
    step(32'h5555_5555, 24'h000009, 1'b1, "R6");
    // R8 / R3 / R4 / R5 sweep over every opcode with both condition values
    for (int op = 0; op < 256; op++) begin
      for (int cp = 0; cp < 2; cp++) begin
        // place the opcode into execute first (never squashed: model holds a non-jump or bubble)
        step({op[7:0], 24'h000000 ^ 24'(op * 37)}, 24'(op * 2 + cp), 1'b0, "R2");
        if (is_jmp(m_insn) && op[3:0] != 0)
          step(32'h7777_0000 | 32'(op), 24'(op + 7), cp[0], cp[0] ? "R8" : "R4");
        else if (is_jmp(m_insn))
          step(32'h7777_0000 | 32'(op), 24'(op + 7), cp[0], cp[0] ? "R3" : "R4");
        else
          step(32'h7777_0000 | 32'(op), 24'(op + 7), cp[0], "R5");
      end
    end
    // R1 reset in mid-stream
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check32("R1", exec_insn, 32'h0);
    check32("R1", {8'h0, exec_pc}, 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule